// File: doc/BRIEF.md
# Hyperspectral block-order address generator

This block turns a description of a hyperspectral cube in memory into a series of read commands for a downstream data mover. Each command is a byte address and a byte length. The cube is cut into rectangular blocks. Each block covers a number of pixel rows, and each pixel holds `depth` spectral components. The generator visits the rows of one block first, then moves to the next block along X. After the last block of a row of blocks, it moves on along Y.

The walk begins at an offset, counted in components, past the base address. Each step from one block to the next adds a programmable skip. A second, separate skip is used after the last block of each row of blocks, so that padding or a different layout between block rows can be covered. The configuration is sampled when a start pulse is accepted. `done` reports that the last command has been taken. `error` reports that the walk stopped on a command that cannot be issued.

A build-time option caps every command at a fixed byte count. This suits a small transfer engine, and with it each row segment is split into several commands.

Top module: `hsi_block_addr_gen`

## Requirements
- R1: After reset, `cmd_valid`, `done` and `error` are low, and they stay low until a start is accepted.
- R2: The first command of a walk has address `cfg_base + cfg_offset * COMP_BYTES`, where `COMP_BYTES` is the component size in bytes.
- R3: Every row of a block is one contiguous span of `(cfg_blk_w_m1 + 1) * cfg_depth * COMP_BYTES` bytes. Row k+1 of a block starts `cfg_cube_width` components after row k, and the block has `cfg_blk_h_m1 + 1` rows. No command has length zero.
- R4: All rows of a block are issued before the next block. Within a row of blocks, each block's first row starts `cfg_skip` components after the first row of the previous block, for `cfg_nblk_x_m1 + 1` blocks.
- R5: After the last block of a row of blocks, the next block starts `cfg_last_skip` components after that last block's first row. X restarts at zero, and the walk ends after `cfg_nblk_y_m1 + 1` rows of blocks.
- R6: With `SMALL_MOVER = 1`, a row is issued as consecutive commands of `MAX_XFER` bytes at rising addresses, ending with the remainder. A row of exactly `MAX_XFER` bytes gives one command. With `SMALL_MOVER = 0`, each row is a single command.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_len` hold their values.
- R8: `done` rises only after the last command of the walk has been accepted. It stays high with no command offered until the next accepted start. The number of accepted commands is exactly the number the walk defines.
- R9: A zero `cfg_depth` raises `error`, issues no command, and leaves `done` low.
- R10: A row whose span would end past byte address 2^32 − 1 raises `error` in place of being issued, and all earlier rows are issued normally. A span ending exactly at 2^32 − 1 is issued.
- R11: A start pulse while a walk is in progress is ignored. The configuration inputs are sampled only at an accepted start.
- R12: An accepted start clears `done` and `error` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only when no walk is running |
| cfg_base | input | 32 | Byte address of the cube's first component |
| cfg_offset | input | 32 | Components from the cube start to the first block |
| cfg_cube_width | input | 20 | Row stride in components |
| cfg_blk_w_m1 | input | 12 | Block width in pixels minus one |
| cfg_blk_h_m1 | input | 12 | Block height in rows minus one |
| cfg_depth | input | 8 | Components per pixel (not biased) |
| cfg_skip | input | 16 | Components between first pixels of adjacent blocks in X |
| cfg_last_skip | input | 16 | Components from the last block of a block row to the next block |
| cfg_nblk_x_m1 | input | 9 | Blocks along X minus one |
| cfg_nblk_y_m1 | input | 9 | Blocks along Y minus one |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The mover accepts the offered command |
| cmd_addr | output | 32 | Command byte address |
| cmd_len | output | LEN_W (24) | Command length in bytes |
| done | output | 1 | Walk finished; held until next start |
| error | output | 1 | Walk stopped on a bad command; held until next start |

## Verification
The assertions assume that `rst` is held for at least one clock before any start. They also assume that `COMP_BYTES`, the block dimensions and the depth give a row length that fits in `LEN_W` bits. The bench uses only configurations whose longest row is a few hundred bytes, so this holds.

The configuration inputs may change at any time, because the block latches them only at an accepted start. The bench exploits this by changing them and pulsing start in the middle of a walk. `cmd_ready` follows a pseudo-random pattern in some runs and stays high in others, so that the hold rule is exercised under backpressure and with no backpressure.

// File: rtl/hsi_agen_pkg.sv
package hsi_agen_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFFS_W  = 32;
  localparam int CUBEW_W = 20;
  localparam int BLK_W   = 12;
  localparam int DEPTH_W = 8;
  localparam int SKIP_W  = 16;
  localparam int NBLK_W  = 9;
  // component index range: offset + rows*stride + blocks*skip stays below 2^36
  localparam int CIDX_W  = 40;

  typedef struct packed {
    logic [ADDR_W-1:0]  base;
    logic [CUBEW_W-1:0] cube_w;
    logic [BLK_W-1:0]   blk_w_m1;
    logic [BLK_W-1:0]   blk_h_m1;
    logic [DEPTH_W-1:0] depth;
    logic [SKIP_W-1:0]  skip;
    logic [SKIP_W-1:0]  last_skip;
    logic [NBLK_W-1:0]  nblk_x_m1;
    logic [NBLK_W-1:0]  nblk_y_m1;
  } walk_cfg_t;
endpackage

// File: rtl/hsi_agen_walker.sv
module hsi_agen_walker
  import hsi_agen_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [OFFS_W-1:0]  start_cidx,
  input  logic [CUBEW_W-1:0] cube_w,
  input  logic [BLK_W-1:0]   blk_h_m1,
  input  logic [SKIP_W-1:0]  skip,
  input  logic [SKIP_W-1:0]  last_skip,
  input  logic [NBLK_W-1:0]  nblk_x_m1,
  input  logic [NBLK_W-1:0]  nblk_y_m1,
  input  logic               row_take,
  output logic               row_valid,
  output logic [CIDX_W-1:0]  row_cidx,
  output logic               fin
);
  logic [BLK_W-1:0]  row_q;
  logic [NBLK_W-1:0] bx_q;
  logic [NBLK_W-1:0] by_q;
  logic [CIDX_W-1:0] org_q;
  logic [CIDX_W-1:0] org_x;
  logic [CIDX_W-1:0] org_y;

  assign org_x = org_q + CIDX_W'(skip);
  assign org_y = org_q + CIDX_W'(last_skip);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q     <= '0;
      bx_q      <= '0;
      by_q      <= '0;
      org_q     <= '0;
      row_cidx  <= '0;
      row_valid <= 1'b0;
      fin       <= 1'b0;
    end else if (launch) begin
      row_q     <= '0;
      bx_q      <= '0;
      by_q      <= '0;
      org_q     <= CIDX_W'(start_cidx);
      row_cidx  <= CIDX_W'(start_cidx);
      row_valid <= 1'b1;
      fin       <= 1'b0;
    end else if (row_valid && row_take) begin
      if (row_q != blk_h_m1) begin
        row_q    <= row_q + 1'b1;
        row_cidx <= row_cidx + CIDX_W'(cube_w);
      end else begin
        row_q <= '0;
        if (bx_q != nblk_x_m1) begin
          bx_q     <= bx_q + 1'b1;
          org_q    <= org_x;
          row_cidx <= org_x;
        end else if (by_q != nblk_y_m1) begin
          bx_q     <= '0;
          by_q     <= by_q + 1'b1;
          org_q    <= org_y;
          row_cidx <= org_y;
        end else begin
          row_valid <= 1'b0;
          fin       <= 1'b1;
        end
      end
    end
  end

  // R4: row counter never leaves the block while rows are pending
  p_row_in_block_r4: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> (row_q <= blk_h_m1));
  // R5: block counters stay inside the programmed grid
  p_blk_in_grid_r5: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> (bx_q <= nblk_x_m1) && (by_q <= nblk_y_m1));
  // R8: a finished walk offers no further rows
  p_fin_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    fin |-> !row_valid);
endmodule

// File: rtl/hsi_agen_emitter.sv
module hsi_agen_emitter
  import hsi_agen_pkg::*;
#(
  parameter int COMP_BYTES  = 2,
  parameter bit SMALL_MOVER = 1'b0,
  parameter int MAX_XFER    = 256,
  parameter int LEN_W       = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [ADDR_W-1:0]  base,
  input  logic [BLK_W-1:0]   blk_w_m1,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               row_valid,
  input  logic [CIDX_W-1:0]  row_cidx,
  output logic               row_take,
  output logic               fault,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [LEN_W-1:0]   cmd_len
);
  localparam int BYTE_W = CIDX_W + 6;
  localparam logic [BYTE_W-1:0] ADDR_TOP = BYTE_W'(1) << ADDR_W;

  logic [BYTE_W-1:0] row_len_w;
  logic [BYTE_W-1:0] row_addr_w;
  logic [BYTE_W-1:0] row_end_w;
  logic              bad_row;
  logic              load;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  rem_next;
  logic [LEN_W-1:0]  first_len;
  logic [LEN_W-1:0]  next_len;
  logic              accept;

  assign row_len_w  = (BYTE_W'(blk_w_m1) + BYTE_W'(1)) * BYTE_W'(depth) * BYTE_W'(COMP_BYTES);
  assign row_addr_w = BYTE_W'(base) + BYTE_W'(row_cidx) * BYTE_W'(COMP_BYTES);
  assign row_end_w  = row_addr_w + row_len_w;
  assign bad_row    = (row_len_w == '0) || (row_end_w > ADDR_TOP);
  assign load       = en && !cmd_valid && row_valid;
  assign row_take   = load && !bad_row;
  assign fault      = load && bad_row;
  assign accept     = cmd_valid && cmd_ready;
  assign rem_next   = rem_q - cmd_len;

  generate
    if (SMALL_MOVER) begin : g_capped
      always_comb begin
        first_len = (row_len_w > BYTE_W'(MAX_XFER)) ? LEN_W'(MAX_XFER) : row_len_w[LEN_W-1:0];
        next_len  = (rem_next > LEN_W'(MAX_XFER)) ? LEN_W'(MAX_XFER) : rem_next;
      end
      // R6: no command exceeds the transfer cap
      p_len_cap_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len <= LEN_W'(MAX_XFER)));
    end else begin : g_whole
      always_comb begin
        first_len = row_len_w[LEN_W-1:0];
        next_len  = rem_next;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      rem_q     <= '0;
    end else if (row_take) begin
      cmd_valid <= 1'b1;
      cmd_addr  <= row_addr_w[ADDR_W-1:0];
      cmd_len   <= first_len;
      rem_q     <= row_len_w[LEN_W-1:0];
    end else if (accept) begin
      if (rem_next == '0) begin
        cmd_valid <= 1'b0;
      end else begin
        cmd_addr <= cmd_addr + ADDR_W'(cmd_len);
        cmd_len  <= next_len;
        rem_q    <= rem_next;
      end
    end
  end

  // R7: an offered command is held until taken
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));
  // R3: no empty command reaches the mover
  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len != '0));
  // R10: every offered span ends inside the 32-bit space
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ((ADDR_W+1)'(cmd_addr) + (ADDR_W+1)'(cmd_len) <= {1'b1, {ADDR_W{1'b0}}}));
endmodule

// File: rtl/hsi_block_addr_gen.sv
module hsi_block_addr_gen
  import hsi_agen_pkg::*;
#(
  parameter int COMP_BYTES  = 2,
  parameter bit SMALL_MOVER = 1'b0,
  parameter int MAX_XFER    = 256,
  parameter int LEN_W       = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [31:0]        cfg_base,
  input  logic [31:0]        cfg_offset,
  input  logic [19:0]        cfg_cube_width,
  input  logic [11:0]        cfg_blk_w_m1,
  input  logic [11:0]        cfg_blk_h_m1,
  input  logic [7:0]         cfg_depth,
  input  logic [15:0]        cfg_skip,
  input  logic [15:0]        cfg_last_skip,
  input  logic [8:0]         cfg_nblk_x_m1,
  input  logic [8:0]         cfg_nblk_y_m1,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [31:0]        cmd_addr,
  output logic [LEN_W-1:0]   cmd_len,
  output logic               done,
  output logic               error
);
  walk_cfg_t         cfg_q;
  logic              run_q;
  logic              launch;
  logic              row_valid;
  logic              row_take;
  logic [CIDX_W-1:0] row_cidx;
  logic              walk_fin;
  logic              fault;

  assign launch = start && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
      cfg_q <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      done  <= 1'b0;
      error <= 1'b0;
      cfg_q <= '{base: cfg_base, cube_w: cfg_cube_width, blk_w_m1: cfg_blk_w_m1,
                 blk_h_m1: cfg_blk_h_m1, depth: cfg_depth, skip: cfg_skip,
                 last_skip: cfg_last_skip, nblk_x_m1: cfg_nblk_x_m1,
                 nblk_y_m1: cfg_nblk_y_m1};
    end else if (run_q) begin
      if (fault) begin
        error <= 1'b1;
        run_q <= 1'b0;
      end else if (walk_fin && !cmd_valid) begin
        done  <= 1'b1;
        run_q <= 1'b0;
      end
    end
  end

  hsi_agen_walker u_walker (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .start_cidx (cfg_offset),
    .cube_w     (cfg_q.cube_w),
    .blk_h_m1   (cfg_q.blk_h_m1),
    .skip       (cfg_q.skip),
    .last_skip  (cfg_q.last_skip),
    .nblk_x_m1  (cfg_q.nblk_x_m1),
    .nblk_y_m1  (cfg_q.nblk_y_m1),
    .row_take   (row_take),
    .row_valid  (row_valid),
    .row_cidx   (row_cidx),
    .fin        (walk_fin)
  );

  hsi_agen_emitter #(
    .COMP_BYTES  (COMP_BYTES),
    .SMALL_MOVER (SMALL_MOVER),
    .MAX_XFER    (MAX_XFER),
    .LEN_W       (LEN_W)
  ) u_emitter (
    .clk       (clk),
    .rst       (rst),
    .en        (run_q),
    .base      (cfg_q.base),
    .blk_w_m1  (cfg_q.blk_w_m1),
    .depth     (cfg_q.depth),
    .row_valid (row_valid),
    .row_cidx  (row_cidx),
    .row_take  (row_take),
    .fault     (fault),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len)
  );

  // R9: the two end states never coexist
  p_end_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  // R8: nothing is offered once the walk reports completion
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid);
  // R11: a start during a walk leaves the sampled setup untouched
  p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
    (run_q && start) |=> $stable(cfg_q));
  // R12: an accepted start clears both end flags
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    launch |=> !done && !error);
endmodule

// File: tb/hsi_block_addr_gen_bench.sv
module hsi_block_addr_gen_bench;
  localparam int CLK_NS = 10;
  localparam int CB     = 2;
  localparam int CAP    = 256;
  localparam int LW     = 24;
  localparam int NEXP   = 64;

  typedef struct packed {
    logic [31:0] base; logic [31:0] off; logic [19:0] cw;
    logic [11:0] bw;   logic [11:0] bh;  logic [7:0]  dp;
    logic [15:0] sk;   logic [15:0] ls;  logic [8:0]  nx;
    logic [8:0]  ny;   logic        bp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0000_1000, 32'd4,  20'd40,   12'd1, 12'd1, 8'd3,  16'd6,   16'd100, 9'd1, 9'd1, 1'b1},
    '{32'h0002_0000, 32'd0,  20'd1000, 12'd9, 12'd0, 8'd20, 16'd0,   16'd500, 9'd0, 9'd2, 1'b0},
    '{32'h0000_0400, 32'd10, 20'd512,  12'd7, 12'd2, 8'd16, 16'd128, 16'd0,   9'd2, 9'd0, 1'b1},
    '{32'h0000_0000, 32'd0,  20'd8,    12'd3, 12'd1, 8'd0,  16'd1,   16'd1,   9'd0, 9'd0, 1'b0},
    '{32'hFFFF_FF00, 32'd0,  20'd64,   12'd0, 12'd3, 8'd16, 16'd0,   16'd0,   9'd0, 9'd0, 1'b1},
    '{32'hFFFF_FFE0, 32'd0,  20'd4,    12'd0, 12'd0, 8'd16, 16'd0,   16'd0,   9'd0, 9'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] cfg_base = '0, cfg_offset = '0;
  logic [19:0] cfg_cube_width = '0;
  logic [11:0] cfg_blk_w_m1 = '0, cfg_blk_h_m1 = '0;
  logic [7:0]  cfg_depth = '0;
  logic [15:0] cfg_skip = '0, cfg_last_skip = '0;
  logic [8:0]  cfg_nblk_x_m1 = '0, cfg_nblk_y_m1 = '0;

  logic          v0, v1, rdy0, rdy1, done0, done1, err0, err1;
  logic [31:0]   a0, a1;
  logic [LW-1:0] l0, l1;

  int  checks = 0, errors = 0, cycles = 0;
  int  n0, n1, got0, got1;
  bit  exp_err, bp_mode;
  logic [15:0] lfsr = 16'hACE1;
  longint exp0_a [NEXP]; longint exp0_l [NEXP];
  longint exp1_a [NEXP]; longint exp1_l [NEXP];

  always #(CLK_NS/2) clk = ~clk;

  hsi_block_addr_gen #(.COMP_BYTES(CB), .SMALL_MOVER(1'b0), .MAX_XFER(CAP), .LEN_W(LW))
  u_hsi_block_addr_gen (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_offset(cfg_offset),
    .cfg_cube_width(cfg_cube_width), .cfg_blk_w_m1(cfg_blk_w_m1), .cfg_blk_h_m1(cfg_blk_h_m1),
    .cfg_depth(cfg_depth), .cfg_skip(cfg_skip), .cfg_last_skip(cfg_last_skip),
    .cfg_nblk_x_m1(cfg_nblk_x_m1), .cfg_nblk_y_m1(cfg_nblk_y_m1),
    .cmd_valid(v0), .cmd_ready(rdy0), .cmd_addr(a0), .cmd_len(l0), .done(done0), .error(err0));

  hsi_block_addr_gen #(.COMP_BYTES(CB), .SMALL_MOVER(1'b1), .MAX_XFER(CAP), .LEN_W(LW))
  u_hsi_block_addr_gen_small (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_offset(cfg_offset),
    .cfg_cube_width(cfg_cube_width), .cfg_blk_w_m1(cfg_blk_w_m1), .cfg_blk_h_m1(cfg_blk_h_m1),
    .cfg_depth(cfg_depth), .cfg_skip(cfg_skip), .cfg_last_skip(cfg_last_skip),
    .cfg_nblk_x_m1(cfg_nblk_x_m1), .cfg_nblk_y_m1(cfg_nblk_y_m1),
    .cmd_valid(v1), .cmd_ready(rdy1), .cmd_addr(a1), .cmd_len(l1), .done(done1), .error(err1));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ready is set first, then a handshake due at the next rising edge is recorded
  always @(negedge clk) begin
    cycles++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy0 = bp_mode ? lfsr[0] : 1'b1;
    rdy1 = bp_mode ? lfsr[3] : 1'b1;
    if (!rst && v0 && rdy0) begin
      if (got0 < n0) begin
        check(a0 == exp0_a[got0][31:0], "R2 R3 R4 R5 address", a0, exp0_a[got0]);
        check(l0 == exp0_l[got0][LW-1:0], "R3 length", l0, exp0_l[got0]);
      end else check(1'b0, "R8 extra command", got0, n0);
      got0++;
    end
    if (!rst && v1 && rdy1) begin
      if (got1 < n1) begin
        check(a1 == exp1_a[got1][31:0], "R6 chunk address", a1, exp1_a[got1]);
        check(l1 == exp1_l[got1][LW-1:0], "R6 chunk length", l1, exp1_l[got1]);
      end else check(1'b0, "R6 extra command", got1, n1);
      got1++;
    end
  end

  task automatic build_expected(input vec_t v);
    longint org, a, len, rem, c;
    bit stop;
    org = longint'(v.off); stop = 0; n0 = 0; n1 = 0; exp_err = 0;
    len = (longint'(v.bw) + 1) * longint'(v.dp) * CB;
    for (int by = 0; by <= int'(v.ny) && !stop; by++) begin
      for (int bx = 0; bx <= int'(v.nx) && !stop; bx++) begin
        for (int r = 0; r <= int'(v.bh) && !stop; r++) begin
          a = longint'(v.base) + (org + longint'(r) * longint'(v.cw)) * CB;
          if (len == 0 || a + len > (longint'(1) << 32)) begin
            stop = 1; exp_err = 1;
          end else begin
            exp0_a[n0] = a; exp0_l[n0] = len; n0++;
            rem = len;
            while (rem > 0) begin
              c = (rem > CAP) ? CAP : rem;
              exp1_a[n1] = a; exp1_l[n1] = c; n1++;
              a += c; rem -= c;
            end
          end
        end
        org += (bx == int'(v.nx)) ? longint'(v.ls) : longint'(v.sk);
      end
    end
  endtask

  task automatic drive_cfg(input vec_t v);
    cfg_base = v.base; cfg_offset = v.off; cfg_cube_width = v.cw;
    cfg_blk_w_m1 = v.bw; cfg_blk_h_m1 = v.bh; cfg_depth = v.dp;
    cfg_skip = v.sk; cfg_last_skip = v.ls; cfg_nblk_x_m1 = v.nx; cfg_nblk_y_m1 = v.ny;
  endtask

  task automatic run_vec(input vec_t v, input bit disturb, input vec_t alt);
    int wait_n;
    build_expected(v);
    drive_cfg(v);
    bp_mode = v.bp; got0 = 0; got1 = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done0 && !err0 && !done1 && !err1, "R12 flags cleared", {done0, err0}, 0);
    wait_n = 0;
    while (!((done0 || err0) && (done1 || err1)) && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
      if (disturb && wait_n == 4) begin
        drive_cfg(alt); start = 1'b1;
      end else if (disturb && wait_n == 5) start = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(got0 == n0, "R8 command count", got0, n0);
    check(got1 == n1, "R6 chunk count", got1, n1);
    check(err0 == exp_err && err1 == exp_err, "R9 R10 error flag", err0, exp_err);
    check(done0 == !exp_err && done1 == !exp_err, "R8 done flag", done0, !exp_err);
    check(!v0 && !v1, "R8 quiet after end", v0, 0);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    check(1'b0, "watchdog", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    n0 = 0; n1 = 0; got0 = 0; got1 = 0; bp_mode = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!v0 && !v1 && !done0 && !done1 && !err0 && !err1, "R1 reset state",
          {v0, v1, done0, done1, err0, err1}, 0);
    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    foreach (VEC[i]) run_vec(VEC[i], 1'b0, VEC[i]);
    // R8: done stays high while idle
    repeat (5) @(negedge clk);
    check(done0 && done1 && !v0 && !v1, "R8 done held", done0, 1);
    // R11: start and new setup mid-walk are ignored
    run_vec(VEC[0], 1'b1, VEC[1]);
    // R12: restart after an error walk
    run_vec(VEC[3], 1'b0, VEC[3]);
    run_vec(VEC[2], 1'b0, VEC[2]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule